// File: doc/BRIEF.md
# Control Command Decoder with Field Validation

This block sits behind a byte receiver that has already filtered traffic by destination, so every byte it sees belongs to a command aimed at this unit. A start-of-command marker flags the first byte of each command. The decoder recognises two commands. The first loads the time of day. The second asks the unit to restart.

For the time-of-day command, the decoder collects five numeric fields and checks each one against its legal range as it arrives. It then presents the whole set on parallel outputs together with a one-cycle load strobe. For the restart command, it compares the trailing address bytes with the unit's own logical address and pulses a restart request when they agree. Malformed input raises a one-cycle error flag. Neither command produces any reply.

Top module: `cmd_decoder`

## Requirements
- R1: While synchronous reset is high and in the cycle after it is released, `clk_load`, `rst_req` and `cmd_err` are low and every clock field output is zero.
- R2: A time-of-day command is the byte 0xFD carried with `in_sop`, then 0x60, then year, month, day, hour and minute in that order, each in its own valid byte. One cycle after the minute byte is accepted, `clk_load` is high for exactly one cycle and the field outputs carry the five received values.
- R3: Each field byte is compared whole against its limit: year 0..15, month 0..11, day 0..30, hour 0..23, minute 0..59. Both ends of every range are accepted.
- R4: A field byte above its limit raises `cmd_err` for one cycle, starting the cycle after that byte. No `clk_load` follows, the field outputs keep their previous values, and later bytes are ignored until the next start marker.
- R5: A restart command is the byte 0xFE carried with `in_sop`, then four address bytes. These are compared with `unit_addr`, bits 31:24 first and bits 7:0 last. If all four match, `rst_req` is high for one cycle, starting the cycle after the fourth byte.
- R6: A restart command with any address byte that differs from `unit_addr` produces neither `rst_req` nor `cmd_err`.
- R7: A byte carried with `in_sop` always starts a new command. Any partially parsed command is dropped without an error or a strobe.
- R8: The following raise `cmd_err` for one cycle: an opcode other than 0xFD or 0xFE on a start byte, or a second byte other than 0x60 after 0xFD. Bytes are then discarded until the next start marker.
- R9: Bytes are consumed only in cycles where `in_valid` is high, so idle cycles between the bytes of a command have no effect. Valid bytes without `in_sop` outside a command are ignored.
- R10: The clock field outputs change only in cycles where `clk_load` is high. At most one of `clk_load`, `rst_req` and `cmd_err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | 8 | Command byte |
| in_valid | input | 1 | `in_byte` is valid this cycle |
| in_sop | input | 1 | This byte is the first byte of a command |
| unit_addr | input | 32 | Unit logical address, first transmitted byte in bits 31:24 |
| clk_year | output | 4 | Loaded year modulo 16 |
| clk_month | output | 4 | Loaded month, zero-based |
| clk_day | output | 5 | Loaded day, zero-based |
| clk_hour | output | 5 | Loaded hour |
| clk_minute | output | 6 | Loaded minute |
| clk_load | output | 1 | One-cycle strobe: new clock fields are valid |
| rst_req | output | 1 | One-cycle restart request |
| cmd_err | output | 1 | One-cycle malformed-command flag |

## Verification
The time-of-day command is tried with typical values, with every field at zero, and with every field at its maximum. These cases separate a correct field order and correct bit slicing from off-by-one limits. Each field is then pushed one step past its limit in turn, which shows whether every field has its own limit and whether the held outputs survive a rejected command. The restart command is sent with a full match, with a mismatch in the first byte and with a mismatch in the last byte, which tells a byte-order error apart from a compare that only looks at some of the bytes. Commands that are interrupted by a new start marker, commands with idle gaps between bytes, and stray bytes outside any command show whether parser state leaks from one command into the next.

// File: rtl/cmd_dec_pkg.sv
`timescale 1ns/1ps
package cmd_dec_pkg;

    localparam logic [7:0] OP_CLOCK     = 8'hFD;
    localparam logic [7:0] OP_CLOCK_SUB = 8'h60;
    localparam logic [7:0] OP_RESTART   = 8'hFE;

    localparam int NUM_FIELDS  = 5;
    localparam int FIELD_IDX_W = $clog2(NUM_FIELDS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SUB,
        ST_FIELD,
        ST_ADDR,
        ST_DROP
    } parse_state_t;

    typedef struct packed {
        logic [3:0] year;
        logic [3:0] month;
        logic [4:0] day;
        logic [4:0] hour;
        logic [5:0] minute;
    } clock_set_t;

    // Largest legal value of each field, in arrival order.
    function automatic logic [7:0] field_limit(input logic [FIELD_IDX_W-1:0] idx);
        case (idx)
            FIELD_IDX_W'(0): field_limit = 8'd15;
            FIELD_IDX_W'(1): field_limit = 8'd11;
            FIELD_IDX_W'(2): field_limit = 8'd30;
            FIELD_IDX_W'(3): field_limit = 8'd23;
            default:         field_limit = 8'd59;
        endcase
    endfunction

endpackage

// File: rtl/cmd_field_check.sv
`timescale 1ns/1ps
module cmd_field_check
    import cmd_dec_pkg::*;
(
    input  logic [FIELD_IDX_W-1:0] idx,
    input  logic [7:0]             value,
    output logic                   ok
);
    assign ok = (value <= field_limit(idx));
endmodule

// File: rtl/cmd_addr_match.sv
`timescale 1ns/1ps
module cmd_addr_match #(
    parameter int ADDR_BYTES = 4,
    localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    step,
    input  logic [IDX_W-1:0]        idx,
    input  logic [7:0]              byte_in,
    input  logic [8*ADDR_BYTES-1:0] unit_addr,
    output logic                    hit
);
    logic [7:0] addr_bytes [ADDR_BYTES];
    logic       running_ok;
    logic       byte_eq;

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_split
        assign addr_bytes[g] = unit_addr[8*(ADDR_BYTES-1-g) +: 8];
    end

    assign byte_eq = (byte_in == addr_bytes[idx]);
    assign hit     = running_ok & byte_eq;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            running_ok <= 1'b1;
        end else if (step) begin
            running_ok <= running_ok & byte_eq;
        end
    end

    // R6
    mismatch_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && !byte_eq) |=> !running_ok);
endmodule

// File: rtl/cmd_clock_stage.sv
`timescale 1ns/1ps
module cmd_clock_stage
    import cmd_dec_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr,
    input  logic [FIELD_IDX_W-1:0] idx,
    input  logic [5:0]             value,
    input  logic                   commit,
    output clock_set_t             shown,
    output logic                   load
);
    clock_set_t staged, staged_n;

    always_comb begin
        staged_n = staged;
        if (wr) begin
            case (idx)
                FIELD_IDX_W'(0): staged_n.year   = value[3:0];
                FIELD_IDX_W'(1): staged_n.month  = value[3:0];
                FIELD_IDX_W'(2): staged_n.day    = value[4:0];
                FIELD_IDX_W'(3): staged_n.hour   = value[4:0];
                default:         staged_n.minute = value;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= '0;
            shown  <= '0;
            load   <= 1'b0;
        end else begin
            staged <= staged_n;
            load   <= commit;
            if (commit) begin
                shown <= staged_n;
            end
        end
    end

    // R10
    shown_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |-> $stable(shown));
endmodule

// File: rtl/cmd_decoder.sv
`timescale 1ns/1ps
module cmd_decoder
    import cmd_dec_pkg::*;
#(
    parameter int ADDR_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [7:0]              in_byte,
    input  logic                    in_valid,
    input  logic                    in_sop,
    input  logic [8*ADDR_BYTES-1:0] unit_addr,
    output logic [3:0]              clk_year,
    output logic [3:0]              clk_month,
    output logic [4:0]              clk_day,
    output logic [4:0]              clk_hour,
    output logic [5:0]              clk_minute,
    output logic                    clk_load,
    output logic                    rst_req,
    output logic                    cmd_err
);
    localparam int AIDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    parse_state_t            state, state_n;
    logic [FIELD_IDX_W-1:0]  fld_idx, fld_idx_n;
    logic [AIDX_W-1:0]       addr_idx, addr_idx_n;
    logic                    start;
    logic                    field_ok, addr_hit;
    logic                    wr_field, commit, addr_clear, addr_step;
    logic                    err_n, rreq_n;
    clock_set_t              shown;

    assign start = in_valid & in_sop;

    always_comb begin
        state_n    = state;
        fld_idx_n  = fld_idx;
        addr_idx_n = addr_idx;
        wr_field   = 1'b0;
        commit     = 1'b0;
        addr_clear = 1'b0;
        addr_step  = 1'b0;
        err_n      = 1'b0;
        rreq_n     = 1'b0;
        if (start) begin
            fld_idx_n  = '0;
            addr_idx_n = '0;
            case (in_byte)
                OP_CLOCK:   state_n = ST_SUB;
                OP_RESTART: begin
                    state_n    = ST_ADDR;
                    addr_clear = 1'b1;
                end
                default: begin
                    state_n = ST_DROP;
                    err_n   = 1'b1;
                end
            endcase
        end else if (in_valid) begin
            case (state)
                ST_SUB: begin
                    if (in_byte == OP_CLOCK_SUB) begin
                        state_n = ST_FIELD;
                    end else begin
                        state_n = ST_DROP;
                        err_n   = 1'b1;
                    end
                end
                ST_FIELD: begin
                    if (field_ok) begin
                        wr_field = 1'b1;
                        if (fld_idx == FIELD_IDX_W'(NUM_FIELDS - 1)) begin
                            commit  = 1'b1;
                            state_n = ST_IDLE;
                        end else begin
                            fld_idx_n = fld_idx + 1'b1;
                        end
                    end else begin
                        err_n   = 1'b1;
                        state_n = ST_IDLE;
                    end
                end
                ST_ADDR: begin
                    addr_step = 1'b1;
                    if (addr_idx == AIDX_W'(ADDR_BYTES - 1)) begin
                        rreq_n  = addr_hit;
                        state_n = ST_IDLE;
                    end else begin
                        addr_idx_n = addr_idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            fld_idx  <= '0;
            addr_idx <= '0;
            cmd_err  <= 1'b0;
            rst_req  <= 1'b0;
        end else begin
            state    <= state_n;
            fld_idx  <= fld_idx_n;
            addr_idx <= addr_idx_n;
            cmd_err  <= err_n;
            rst_req  <= rreq_n;
        end
    end

    cmd_field_check u_check (
        .idx   (fld_idx),
        .value (in_byte),
        .ok    (field_ok)
    );

    cmd_addr_match #(.ADDR_BYTES(ADDR_BYTES)) u_match (
        .clk       (clk),
        .rst       (rst),
        .clear     (addr_clear),
        .step      (addr_step),
        .idx       (addr_idx),
        .byte_in   (in_byte),
        .unit_addr (unit_addr),
        .hit       (addr_hit)
    );

    cmd_clock_stage u_stage (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_field),
        .idx    (fld_idx),
        .value  (in_byte[5:0]),
        .commit (commit),
        .shown  (shown),
        .load   (clk_load)
    );

    assign clk_year   = shown.year;
    assign clk_month  = shown.month;
    assign clk_day    = shown.day;
    assign clk_hour   = shown.hour;
    assign clk_minute = shown.minute;

    // R10
    one_event_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({clk_load, rst_req, cmd_err}) <= 1);

    // R3
    load_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        clk_load |-> (clk_month <= 4'd11 && clk_day <= 5'd30 &&
                      clk_hour <= 5'd23 && clk_minute <= 6'd59));

    // R5
    rst_req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R9
    err_needs_byte_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> $past(in_valid));

    // R9
    idle_no_move_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(state));
endmodule

// File: tb/tb_cmd_decoder.sv
`timescale 1ns/1ps
module tb_cmd_decoder;

    localparam logic [31:0] MY_ADDR = 32'hE0BF_4E05;

    typedef struct {
        int          kind;   // 0 load, 1 restart, 2 error
        logic [23:0] f;
        string       req;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  in_byte = '0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic [3:0]  clk_year, clk_month;
    logic [4:0]  clk_day, clk_hour;
    logic [5:0]  clk_minute;
    logic        clk_load, rst_req, cmd_err;

    ev_t exp_q[$];
    int  n_vec = 0;
    int  n_bad = 0;
    logic [23:0] last_loaded = '0;

    always #2.5 clk = ~clk;

    cmd_decoder dut (
        .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid),
        .in_sop(in_sop), .unit_addr(MY_ADDR),
        .clk_year(clk_year), .clk_month(clk_month), .clk_day(clk_day),
        .clk_hour(clk_hour), .clk_minute(clk_minute),
        .clk_load(clk_load), .rst_req(rst_req), .cmd_err(cmd_err)
    );

    function automatic logic [23:0] pack(int y, int m, int d, int h, int mi);
        return {4'(y), 4'(m), 5'(d), 5'(h), 6'(mi)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Monitor: pops one expected item per observed event.
    always @(negedge clk) begin
        if (!rst && (clk_load || rst_req || cmd_err)) begin
            int   k;
            ev_t  e;
            k = clk_load ? 0 : (rst_req ? 1 : 2);
            if (exp_q.size() == 0) begin
                check(1'b0, "R6", "unexpected event kind", 32'(k), 32'hFFFF);
            end else begin
                e = exp_q.pop_front();
                check(k == e.kind, e.req, "event kind", 32'(k), 32'(e.kind));
                if (k == 0 && e.kind == 0)
                    check({clk_year, clk_month, clk_day, clk_hour, clk_minute} == e.f,
                          e.req, "loaded fields",
                          32'({clk_year, clk_month, clk_day, clk_hour, clk_minute}),
                          32'(e.f));
            end
        end
    end

    task automatic push(input int kind, input logic [23:0] f, input string req);
        ev_t e;
        e.kind = kind; e.f = f; e.req = req;
        exp_q.push_back(e);
        if (kind == 0) last_loaded = f;
    endtask

    task automatic send(input logic [7:0] b, input bit sop, input int gap);
        @(negedge clk);
        in_byte  = b;
        in_valid = 1'b1;
        in_sop   = sop;
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sop   = 1'b0;
            in_byte  = 8'hA5;
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_clk(input int y, input int m, input int d,
                            input int h, input int mi, input int gap);
        send(8'hFD, 1'b1, gap);
        send(8'h60, 1'b0, gap);
        send(8'(y), 1'b0, gap);
        send(8'(m), 1'b0, gap);
        send(8'(d), 1'b0, gap);
        send(8'(h), 1'b0, gap);
        send(8'(mi), 1'b0, gap);
    endtask

    task automatic send_rst(input logic [31:0] a);
        send(8'hFE, 1'b1, 0);
        for (int i = 3; i >= 0; i--) send(a[8*i +: 8], 1'b0, 0);
    endtask

    task automatic drain(input string req);
        idle(4);
        check(exp_q.size() == 0, req, "pending expected events",
              32'(exp_q.size()), 32'd0);
        exp_q.delete();
    endtask

    task automatic hold(input string req);
        check({clk_year, clk_month, clk_day, clk_hour, clk_minute} == last_loaded,
              req, "held fields",
              32'({clk_year, clk_month, clk_day, clk_hour, clk_minute}),
              32'(last_loaded));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check({clk_load, rst_req, cmd_err} == 3'b000, "R1", "strobes in reset",
              32'({clk_load, rst_req, cmd_err}), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check({clk_load, rst_req, cmd_err} == 3'b000, "R1", "strobes after reset",
              32'({clk_load, rst_req, cmd_err}), 32'd0);
        hold("R1");

        // R2: typical set-clock
        push(0, pack(5, 3, 14, 13, 42), "R2");
        send_clk(5, 3, 14, 13, 42, 0);
        drain("R2");
        hold("R2");

        // R3: maxima then minima
        push(0, pack(15, 11, 30, 23, 59), "R3");
        send_clk(15, 11, 30, 23, 59, 0);
        drain("R3");
        push(0, pack(0, 0, 0, 0, 0), "R3");
        send_clk(0, 0, 0, 0, 0, 0);
        drain("R3");

        push(0, pack(1, 2, 3, 4, 5), "R2");
        send_clk(1, 2, 3, 4, 5, 0);
        drain("R2");

        // R4: each field one above its limit
        push(2, '0, "R4"); send_clk(16, 2, 3, 4, 5, 0);  drain("R4"); hold("R4");
        push(2, '0, "R4"); send_clk(7, 12, 5, 6, 7, 0);  drain("R4"); hold("R4");
        push(2, '0, "R4"); send_clk(7, 1, 31, 6, 7, 0);  drain("R4"); hold("R4");
        push(2, '0, "R4"); send_clk(7, 1, 5, 24, 7, 0);  drain("R4"); hold("R4");
        push(2, '0, "R4"); send_clk(7, 1, 5, 6, 60, 0);  drain("R4"); hold("R4");

        // R8: bad sub-opcode, trailing bytes ignored
        push(2, '0, "R8");
        send(8'hFD, 1'b1, 0); send(8'h61, 1'b0, 0);
        send(8'h60, 1'b0, 0); send(8'h01, 1'b0, 0); send(8'h01, 1'b0, 0);
        drain("R8");
        // R8: unknown opcode, trailing bytes including 0xFD ignored
        push(2, '0, "R8");
        send(8'h12, 1'b1, 0); send(8'hFD, 1'b0, 0); send(8'h60, 1'b0, 0);
        send(8'hFE, 1'b0, 0);
        drain("R8");
        hold("R8");

        // R5: matching restart
        push(1, '0, "R5");
        send_rst(MY_ADDR);
        drain("R5");

        // R6: mismatch in last byte, then first byte
        send_rst(MY_ADDR ^ 32'h0000_0001);
        drain("R6");
        send_rst(MY_ADDR ^ 32'h8000_0000);
        drain("R6");

        // R7: clock command cut short by restart
        push(1, '0, "R7");
        send(8'hFD, 1'b1, 0); send(8'h60, 1'b0, 0); send(8'h02, 1'b0, 0);
        send_rst(MY_ADDR);
        drain("R7");
        // R7: restart cut short by clock command
        push(0, pack(9, 8, 7, 6, 5), "R7");
        send(8'hFE, 1'b1, 0); send(8'hE0, 1'b0, 0);
        send_clk(9, 8, 7, 6, 5, 0);
        drain("R7");

        // R9: idle gaps between bytes, stray bytes outside commands
        push(0, pack(3, 10, 29, 22, 58), "R9");
        send_clk(3, 10, 29, 22, 58, 2);
        drain("R9");
        send(8'h60, 1'b0, 0); send(8'h01, 1'b0, 0); send(8'hFE, 1'b0, 0);
        drain("R9");
        hold("R10");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule